// File: doc/BRIEF.md
# Watchdog Host Command Mailbox

This block sits between a byte-wide host register port and a watchdog timer core. The host uses it to run short commands against the timer. It first places argument bytes in two data registers, then writes an opcode. The mailbox marks the command as pending, waits a fixed number of processing cycles, and then executes it. A command may read the timer status, the firmware version, the time left or the reset count, or it may load a new timeout. The result goes into the two data registers, and a response-ready flag is raised.

The host polls the control register until the response-ready flag is set. It then reads the result bytes and reads the opcode register, and that last read acknowledges the response. The timer core is outside this block. It is reached through side signals: a timeout load strobe with its value, the time left, a status byte, a reset count with a clear strobe, and firmware version constants fixed by parameters.

Top module: `wdog_cmd_mailbox`

## Requirements
- R1: After synchronous reset, the control register (offset 2), both data registers and the loaded timeout value read as zero, and no strobe to the timer is active.
- R2: A host write to offset 6 while no command is pending latches the written byte as the opcode. It sets the pending flag (bit 7 of offset 2) and clears the response-ready flag (bit 6 of offset 2). The two flags are never set together.
- R3: Exactly PROC_CYCLES clock edges after the accepting edge of an opcode write, the pending flag clears and the response-ready flag sets on the same edge.
- R4: A host read of offset 6 returns the latched opcode and clears the response-ready flag.
- R5: Opcode 0x19 loads the timer with the value 256 × (offset 5 byte) + (offset 4 byte). At completion it raises the load strobe for exactly one cycle, presents the value on the load-value output, and leaves the data registers unchanged.
- R6: Opcode 0x84 returns the reset count in the offset 4 byte and zero in the offset 5 byte. It pulses the reset-count clear strobe for exactly one cycle in the same step.
- R7: Opcode 0x04 returns the status byte at offset 4 with zero at offset 5. Opcode 0x08 returns the firmware major number at offset 5 and the minor number at offset 4. Opcode 0x18 returns the time left, with the low byte at offset 4 and the high byte at offset 5.
- R8: An opcode write received while a command is pending is ignored. The running opcode and its result are unaffected.
- R9: Any opcode not listed completes normally, with zero in both data registers.
- R10: Host writes to offsets 4 and 5 read back at those offsets. Reads of offsets other than 2, 4, 5 and 6 return zero, and bits 5..0 of offset 2 read zero. Read data is registered and appears the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| tmr_status | input | 8 | Status byte from the timer core |
| tmr_left | input | 16 | Time left from the timer core |
| rst_count | input | 8 | Reset count from the timer core |
| tmr_load | output | 1 | One-cycle timeout load strobe |
| tmr_load_val | output | 16 | Timeout value to load |
| rst_count_clr | output | 1 | One-cycle reset-count clear strobe |

## Verification
The bench times the handshake edge by edge. It holds a continuous read of the control register across a command, so a design that completes one cycle early or late shows a wrong pending or ready pattern. A second opcode is written in the cycle right after the first. A design that does not ignore it reports the wrong status and the wrong opcode. The bench also checks that the timeout load keeps the data bytes and that read-and-clear produces exactly one clear pulse, which catches a result written over the argument or a strobe held for several cycles. Unknown opcodes are sent over non-zero data, so a design that leaves the old bytes in place is exposed.

// File: rtl/wdm_pkg.sv
package wdm_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LO   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_HI   = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_OP   = 3'd6;

  localparam logic [BYTE_W-1:0] OP_STATUS = 8'h04;
  localparam logic [BYTE_W-1:0] OP_FWVER  = 8'h08;
  localparam logic [BYTE_W-1:0] OP_TLEFT  = 8'h18;
  localparam logic [BYTE_W-1:0] OP_TLOAD  = 8'h19;
  localparam logic [BYTE_W-1:0] OP_RCOUNT = 8'h84;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              wr_data;
    logic              load;
    logic              clr;
  } result_t;
endpackage

// File: rtl/wdm_decode.sv
module wdm_decode
  import wdm_pkg::*;
(
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_op,
  output logic              rd_op
);
  always_comb begin
    wr_lo = bus_wr && (bus_addr == OFS_LO);
    wr_hi = bus_wr && (bus_addr == OFS_HI);
    wr_op = bus_wr && (bus_addr == OFS_OP);
    rd_op = bus_rd && (bus_addr == OFS_OP);
  end
endmodule

// File: rtl/wdm_seq.sv
module wdm_seq
  import wdm_pkg::*;
#(
  parameter int PROC_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ack,
  input  logic [BYTE_W-1:0] wdata,
  output logic              pend,
  output logic              ready,
  output logic              done,
  output logic [BYTE_W-1:0] op
);
  localparam int CW = $clog2(PROC_CYCLES + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(PROC_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      ready <= 1'b0;
      cnt   <= '0;
      op    <= '0;
    end else begin
      if (ack) ready <= 1'b0;
      if (pend) begin
        if (cnt == '0) begin
          pend  <= 1'b0;
          ready <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        pend  <= 1'b1;
        ready <= 1'b0;
        cnt   <= CNT_INIT;
        op    <= wdata;
      end
    end
  end

  assign done = pend && (cnt == '0);

  // age of the pending command, for the bounded-handshake check
  logic [CW:0] age;
  always_ff @(posedge clk) begin
    if (rst || !pend) age <= '0;
    else              age <= age + 1'b1;
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pend, ready}));
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !pend) |=> (pend && !ready && op == $past(wdata)));
  p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (pend && !done) |=> (pend && $stable(op)));
  p_done_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> (ready && !pend));
  p_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (ack && !pend && !start) |=> !ready);
  p_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    pend |-> (age < (CW+1)'(PROC_CYCLES)));
endmodule

// File: rtl/wdm_exec.sv
module wdm_exec
  import wdm_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FW_MAJOR = 8'h02,
  parameter logic [BYTE_W-1:0] FW_MINOR = 8'h11
) (
  input  logic [BYTE_W-1:0]   op,
  input  logic [BYTE_W-1:0]   tmr_status,
  input  logic [2*BYTE_W-1:0] tmr_left,
  input  logic [BYTE_W-1:0]   rst_count,
  output result_t             res
);
  always_comb begin
    res = '{lo: '0, hi: '0, wr_data: 1'b1, load: 1'b0, clr: 1'b0};
    case (op)
      OP_STATUS: res.lo = tmr_status;
      OP_FWVER: begin
        res.lo = FW_MINOR;
        res.hi = FW_MAJOR;
      end
      OP_TLEFT: begin
        res.lo = tmr_left[BYTE_W-1:0];
        res.hi = tmr_left[2*BYTE_W-1:BYTE_W];
      end
      OP_TLOAD: begin
        res.wr_data = 1'b0;
        res.load    = 1'b1;
      end
      OP_RCOUNT: begin
        res.lo  = rst_count;
        res.clr = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wdog_cmd_mailbox.sv
module wdog_cmd_mailbox
  import wdm_pkg::*;
#(
  parameter int                PROC_CYCLES = 4,
  parameter logic [BYTE_W-1:0] FW_MAJOR    = 8'h02,
  parameter logic [BYTE_W-1:0] FW_MINOR    = 8'h11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic [BYTE_W-1:0]   tmr_status,
  input  logic [2*BYTE_W-1:0] tmr_left,
  input  logic [BYTE_W-1:0]   rst_count,
  output logic                tmr_load,
  output logic [2*BYTE_W-1:0] tmr_load_val,
  output logic                rst_count_clr
);
  logic wr_lo, wr_hi, wr_op, rd_op;
  logic pend, ready, done;
  logic [BYTE_W-1:0] op, data_lo, data_hi;
  result_t res;

  wdm_decode u_decode (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_op(wr_op), .rd_op(rd_op)
  );

  wdm_seq #(.PROC_CYCLES(PROC_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .start(wr_op), .ack(rd_op), .wdata(bus_wdata),
    .pend(pend), .ready(ready), .done(done), .op(op)
  );

  wdm_exec #(.FW_MAJOR(FW_MAJOR), .FW_MINOR(FW_MINOR)) u_exec (
    .op(op), .tmr_status(tmr_status), .tmr_left(tmr_left),
    .rst_count(rst_count), .res(res)
  );

  // data bytes: result of a completing command wins over a host write
  always_ff @(posedge clk) begin
    if (rst) begin
      data_lo <= '0;
      data_hi <= '0;
    end else if (done && res.wr_data) begin
      data_lo <= res.lo;
      data_hi <= res.hi;
    end else begin
      if (wr_lo) data_lo <= bus_wdata;
      if (wr_hi) data_hi <= bus_wdata;
    end
  end

  // side strobes to the timer core
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_load      <= 1'b0;
      tmr_load_val  <= '0;
      rst_count_clr <= 1'b0;
    end else begin
      tmr_load      <= done && res.load;
      rst_count_clr <= done && res.clr;
      if (done && res.load) tmr_load_val <= {data_hi, data_lo};
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_CTRL: bus_rdata <= {pend, ready, {(BYTE_W-2){1'b0}}};
        OFS_LO:   bus_rdata <= data_lo;
        OFS_HI:   bus_rdata <= data_hi;
        OFS_OP:   bus_rdata <= op;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  p_load_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    tmr_load |=> !tmr_load);
  p_load_val_r5: assert property (@(posedge clk) disable iff (rst)
    tmr_load |-> (tmr_load_val == {data_hi, data_lo}));
  p_clr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rst_count_clr |=> !rst_count_clr);
  p_clr_data_r6: assert property (@(posedge clk) disable iff (rst)
    rst_count_clr |-> (data_hi == '0 && data_lo == $past(rst_count)));
endmodule

// File: tb/test_wdog_cmd_mailbox.sv
module test_wdog_cmd_mailbox;
  localparam int D = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] tmr_status = 8'h5A;
  logic [15:0] tmr_left = 16'hBEEF;
  logic [7:0] rst_count = 8'h07;
  logic tmr_load, rst_count_clr;
  logic [15:0] tmr_load_val;

  int checks = 0, errors = 0, cycles = 0;
  int load_pulses = 0, clr_pulses = 0;

  always #4 clk = ~clk;

  wdog_cmd_mailbox #(.PROC_CYCLES(D), .FW_MAJOR(8'h02), .FW_MINOR(8'h11)) i_wdog_cmd_mailbox (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_status(tmr_status),
    .tmr_left(tmr_left), .rst_count(rst_count), .tmr_load(tmr_load),
    .tmr_load_val(tmr_load_val), .rst_count_clr(rst_count_clr));

  // behavioural reference model
  int m_pend, m_ready, m_cnt, m_lo, m_hi, m_op, m_rdata, m_load, m_lval, m_clr;
  always @(posedge clk) begin
    int olo, ohi, opend, oready;
    if (rst) begin
      m_pend = 0; m_ready = 0; m_cnt = 0; m_lo = 0; m_hi = 0; m_op = 0;
      m_rdata = 0; m_load = 0; m_lval = 0; m_clr = 0;
    end else begin
      olo = m_lo; ohi = m_hi; opend = m_pend; oready = m_ready;
      m_load = 0; m_clr = 0;
      if (bus_rd) begin
        case (bus_addr)
          3'd2: m_rdata = opend * 128 + oready * 64;
          3'd4: m_rdata = olo;
          3'd5: m_rdata = ohi;
          3'd6: m_rdata = m_op;
          default: m_rdata = 0;
        endcase
        if (bus_addr == 3'd6) m_ready = 0;
      end
      if (bus_wr && bus_addr == 3'd4) m_lo = bus_wdata;
      if (bus_wr && bus_addr == 3'd5) m_hi = bus_wdata;
      if (opend) begin
        if (m_cnt == 0) begin
          m_pend = 0; m_ready = 1;
          case (m_op)
            8'h04: begin m_lo = tmr_status; m_hi = 0; end
            8'h08: begin m_lo = 8'h11; m_hi = 8'h02; end
            8'h18: begin m_lo = tmr_left % 256; m_hi = tmr_left / 256; end
            8'h19: begin m_load = 1; m_lval = ohi * 256 + olo; end
            8'h84: begin m_lo = rst_count; m_hi = 0; m_clr = 1; end
            default: begin m_lo = 0; m_hi = 0; end
          endcase
        end else m_cnt = m_cnt - 1;
      end else if (bus_wr && bus_addr == 3'd6) begin
        m_op = bus_wdata; m_pend = 1; m_ready = 0; m_cnt = D - 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      checks++;
      if (bus_rdata !== 8'(m_rdata)) begin
        errors++; $display("FAIL R10 rdata actual %h expected %h", bus_rdata, 8'(m_rdata));
      end
      if (tmr_load !== 1'(m_load) || tmr_load_val !== 16'(m_lval)) begin
        errors++; $display("FAIL R5 load actual %b/%h expected %b/%h",
                           tmr_load, tmr_load_val, 1'(m_load), 16'(m_lval));
      end
      if (rst_count_clr !== 1'(m_clr)) begin
        errors++; $display("FAIL R6 clr actual %b expected %b", rst_count_clr, 1'(m_clr));
      end
      if (tmr_load === 1'b1) load_pulses++;
      if (rst_count_clr === 1'b1) clr_pulses++;
    end
    if (cycles > 20000) begin
      errors++; $display("FAIL watchdog actual expired expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++; $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  task automatic run(input logic [7:0] opc);
    wr(3'd6, opc);
    repeat (D + 1) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(3'd2, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd4, v); chk("R1 lo", v, 8'h00);
    chk("R1 load_val", tmr_load_val, 16'h0000);
    // R10 readback and unused offsets
    wr(3'd4, 8'h3C); rd(3'd4, v); chk("R10 lo readback", v, 8'h3C);
    rd(3'd3, v); chk("R10 unused offset", v, 8'h00);
    // R2 / R3 handshake timing with a held control read
    wr(3'd6, 8'h04);
    bus_rd = 1; bus_addr = 3'd2;
    for (int k = 1; k <= D + 1; k++) begin
      @(negedge clk);
      if (k <= D) chk("R2 pending", bus_rdata, 8'h80);
      else        chk("R3 ready", bus_rdata, 8'h40);
    end
    bus_rd = 0;
    // R7 status
    rd(3'd4, v); chk("R7 status lo", v, 8'h5A);
    rd(3'd5, v); chk("R7 status hi", v, 8'h00);
    // R4 ack
    rd(3'd6, v); chk("R4 opcode readback", v, 8'h04);
    rd(3'd2, v); chk("R4 ready cleared", v, 8'h00);
    // R7 firmware and time left
    run(8'h08);
    rd(3'd5, v); chk("R7 fw major", v, 8'h02);
    rd(3'd4, v); chk("R7 fw minor", v, 8'h11);
    run(8'h18);
    rd(3'd4, v); chk("R7 left lo", v, 8'hEF);
    rd(3'd5, v); chk("R7 left hi", v, 8'hBE);
    // R5 timeout load
    wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    run(8'h19);
    chk("R5 load value", tmr_load_val, 16'h1234);
    chk("R5 one pulse", load_pulses, 1);
    rd(3'd4, v); chk("R5 lo kept", v, 8'h34);
    // R6 reset count read-and-clear
    run(8'h84);
    rd(3'd4, v); chk("R6 count lo", v, 8'h07);
    rd(3'd5, v); chk("R6 count hi", v, 8'h00);
    chk("R6 one clear pulse", clr_pulses, 1);
    // R8 opcode during pending ignored
    @(negedge clk); bus_wr = 1; bus_addr = 3'd6; bus_wdata = 8'h04;
    @(negedge clk); bus_wdata = 8'h08;
    @(negedge clk); bus_wr = 0;
    repeat (D + 1) @(negedge clk);
    rd(3'd6, v); chk("R8 opcode kept", v, 8'h04);
    rd(3'd4, v); chk("R8 status result", v, 8'h5A);
    // R9 unknown opcode
    wr(3'd4, 8'hAA); wr(3'd5, 8'hBB);
    run(8'h33);
    rd(3'd2, v); chk("R9 completes", v, 8'h40);
    rd(3'd4, v); chk("R9 lo zero", v, 8'h00);
    rd(3'd5, v); chk("R9 hi zero", v, 8'h00);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule